// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block holds a 64-bit user segment of one-time-programmable storage, split into four 16-bit words, and a small lock word. Each program request carries a word index and 16 bits of data. When the block accepts a request, it starts a program engine that stays busy for a fixed number of cycles. At the end of that time it commits the new value. Programming can only turn ones into zeros: the stored word becomes the old word ANDed with the request data.

The lock word has two active bits. Clearing the guard bit (bit 1) freezes the user segment. The guard bit also protects the secure bit (bit 2). Clearing the secure bit permanently protects a separate security area, which this block represents only by a flag. A request that targets a protected or nonexistent area sets a sticky error flag and changes nothing. A request that arrives while the engine is busy is ignored, because a program operation cannot be paused or queued. Reset models a blank part: every bit reads 1.

Top module: `otp_protection_reg`

## Requirements
- R1: After reset, `user_bits` is all ones, `lock_bits` is 16'hFFFF, and `busy`, `prot_err` and `secure_locked` are 0.
- R2: A request that is accepted (`req_valid` high while `busy` is low, with no fault) raises `busy` at the next edge. `busy` stays high for exactly PRG_CYCLES cycles, and the new value appears in the same cycle that `busy` falls.
- R3: A user word program (index 0..3, where word n occupies bits 16n+15..16n of `user_bits`) stores old AND data, so no stored bit ever goes from 0 to 1.
- R4: A request presented while `busy` is high is ignored. It does not change the outcome of the running operation, and no later operation runs because of it.
- R5: While lock bit 1 is 0, a request to index 0..3 sets `prot_err` and leaves `user_bits` unchanged.
- R6: Index 4 addresses the lock word. Only data bits 1 and 2 take effect, each ANDed into the stored bit. All other bits of `lock_bits` always read 1.
- R7: While lock bit 1 is 0, a lock-word request with data bit 2 at 0, while lock bit 2 is still 1, sets `prot_err` and leaves `lock_bits` unchanged. A single lock-word request issued while bit 1 is still 1 may clear bits 1 and 2 together.
- R8: `secure_locked` equals the inverse of lock bit 2. Once it is set, it stays high until reset.
- R9: A request to index 5, 6 or 7 sets `prot_err` and changes no state.
- R10: `prot_err` stays set until `err_clr` is asserted. If a new fault arrives in the same cycle as `err_clr`, the error flag stays set.
- R11: Protection cannot be undone. Writing ones never restores a lock bit or a user bit that has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Program request strobe |
| req_index | input | 3 | Word index: 0..3 user words, 4 lock word |
| req_data | input | 16 | Program data; a 0 bit clears the stored bit |
| err_clr | input | 1 | Clears the sticky error flag |
| busy | output | 1 | Program engine running |
| prot_err | output | 1 | Sticky fault flag for the status register |
| user_bits | output | 64 | User segment contents, word 0 in the low bits |
| lock_bits | output | 16 | Lock word; bit 1 is the guard bit, bit 2 the secure bit |
| secure_locked | output | 1 | Security area permanently protected |

## Verification
A wrong lock bit is visible at once on `lock_bits`. It also reveals itself on the next request: that request either raises `prot_err` in the cycle after acceptance when it should not, or starts `busy` when it should have faulted. A corrupted pending index or data value stays hidden until the commit edge, PRG_CYCLES cycles after acceptance. It then shows up as the wrong word changing in `user_bits`. A broken busy counter shows up as a `busy` pulse of the wrong length, or as a second request that should have been dropped being taken.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int GUARD_BIT  = 1;
    localparam int SECURE_BIT = 2;
endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign busy = t_q.run;
    assign done = t_q.run && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = CW'(CYCLES - 1);
        end else if (done) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/otp_req_check.sv
module otp_req_check #(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             clear_secure,
    input  logic             guard_intact,
    input  logic             secure_intact,
    output logic             fault
);
    localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(NUM_WORDS);

    always_comb begin
        if (idx < LOCK_IDX)
            fault = !guard_intact;
        else if (idx == LOCK_IDX)
            fault = !guard_intact && clear_secure && secure_intact;
        else
            fault = 1'b1;
    end
endmodule

// File: rtl/otp_protection_reg.sv
module otp_protection_reg #(
    parameter int WORD_W     = 16,
    parameter int NUM_WORDS  = 4,
    parameter int PRG_CYCLES = 4,
    parameter int IDX_W      = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [IDX_W-1:0]            req_index,
    input  logic [WORD_W-1:0]           req_data,
    input  logic                        err_clr,
    output logic                        busy,
    output logic                        prot_err,
    output logic [NUM_WORDS*WORD_W-1:0] user_bits,
    output logic [WORD_W-1:0]           lock_bits,
    output logic                        secure_locked
);
    import otp_pkg::*;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic                             guard;
        logic                             secure;
        logic                             err;
        logic [IDX_W-1:0]                 pend_idx;
        logic [WORD_W-1:0]                pend_data;
    } otp_st_t;

    otp_st_t st_d, st_q;
    logic    accept, fault, start, done;

    otp_req_check #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) i_check (
        .idx          (req_index),
        .clear_secure (!req_data[SECURE_BIT]),
        .guard_intact (st_q.guard),
        .secure_intact(st_q.secure),
        .fault        (fault)
    );

    otp_busy_timer #(.CYCLES(PRG_CYCLES)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy),
        .done (done)
    );

    assign accept = req_valid && !busy;
    assign start  = accept && !fault;

    always_comb begin
        st_d = st_q;
        if (err_clr) st_d.err = 1'b0;
        if (accept && fault) st_d.err = 1'b1;
        if (start) begin
            st_d.pend_idx  = req_index;
            st_d.pend_data = req_data;
        end
        if (done) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (st_q.pend_idx == IDX_W'(i))
                    st_d.words[i] = st_q.words[i] & st_q.pend_data;
            end
            if (st_q.pend_idx == IDX_W'(NUM_WORDS)) begin
                st_d.guard  = st_q.guard  & st_q.pend_data[GUARD_BIT];
                st_d.secure = st_q.secure & st_q.pend_data[SECURE_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.words     <= '1;
            st_q.guard     <= 1'b1;
            st_q.secure    <= 1'b1;
            st_q.err       <= 1'b0;
            st_q.pend_idx  <= '0;
            st_q.pend_data <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_lock
            if (b == GUARD_BIT) begin : g_guard
                assign lock_bits[b] = st_q.guard;
            end else if (b == SECURE_BIT) begin : g_sec
                assign lock_bits[b] = st_q.secure;
            end else begin : g_fix
                assign lock_bits[b] = 1'b1;
            end
        end
    endgenerate

    assign user_bits     = st_q.words;
    assign prot_err      = st_q.err;
    assign secure_locked = !st_q.secure;
endmodule

// File: rtl/otp_prot_checker.sv
module otp_prot_checker #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        busy,
    input logic                        prot_err,
    input logic                        err_clr,
    input logic [NUM_WORDS*WORD_W-1:0] user_bits,
    input logic [WORD_W-1:0]           lock_bits,
    input logic                        secure_locked
);
    a_r3_user_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((user_bits & ~$past(user_bits)) == '0));

    a_r11_lock_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_bits & ~$past(lock_bits)) == '0));

    a_r11_guard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_bits[1] |=> !lock_bits[1]);

    a_r8_secure_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        secure_locked |=> secure_locked);

    a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !err_clr) |=> prot_err);

    a_r2_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(user_bits) && $stable(lock_bits)));
endmodule

bind otp_protection_reg otp_prot_checker #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_prot_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .prot_err     (prot_err),
    .err_clr      (err_clr),
    .user_bits    (user_bits),
    .lock_bits    (lock_bits),
    .secure_locked(secure_locked)
);

// File: tb/test_otp_protection_reg.sv
module test_otp_protection_reg;
    localparam int PRG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_index = '0;
    logic [15:0] req_data = '0;
    logic        err_clr = 1'b0;
    logic        busy, prot_err, secure_locked;
    logic [63:0] user_bits;
    logic [15:0] lock_bits;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    otp_protection_reg #(.PRG_CYCLES(PRG)) i_otp_protection_reg (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_data(req_data), .err_clr(err_clr), .busy(busy), .prot_err(prot_err),
        .user_bits(user_bits), .lock_bits(lock_bits), .secure_locked(secure_locked)
    );

    typedef struct packed {
        logic [2:0]  idx;
        logic [15:0] data;
        logic        err;
        logic [63:0] user;
        logic [15:0] lock;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{3'd0, 16'hFF00, 1'b0, 64'hFFFF_FFFF_FFFF_FF00, 16'hFFFF},
        '{3'd0, 16'h0FF0, 1'b0, 64'hFFFF_FFFF_FFFF_0F00, 16'hFFFF},
        '{3'd0, 16'hFFFF, 1'b0, 64'hFFFF_FFFF_FFFF_0F00, 16'hFFFF},
        '{3'd3, 16'h1234, 1'b0, 64'h1234_FFFF_FFFF_0F00, 16'hFFFF},
        '{3'd5, 16'h0000, 1'b1, 64'h1234_FFFF_FFFF_0F00, 16'hFFFF},
        '{3'd4, 16'hFFFD, 1'b0, 64'h1234_FFFF_FFFF_0F00, 16'hFFFD},
        '{3'd1, 16'h0000, 1'b1, 64'h1234_FFFF_FFFF_0F00, 16'hFFFD},
        '{3'd4, 16'hFFFB, 1'b1, 64'h1234_FFFF_FFFF_0F00, 16'hFFFD},
        '{3'd4, 16'hFFFF, 1'b0, 64'h1234_FFFF_FFFF_0F00, 16'hFFFD}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic issue(input logic [2:0] idx, input logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 user", user_bits, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1 lock", {48'd0, lock_bits}, 64'h0000_0000_0000_FFFF);
        check("R1 flags", {61'd0, busy, prot_err, secure_locked}, 64'd0);

        // R3 R5 R6 R7 R9 R11 vector walk
        for (int i = 0; i < 9; i++) begin
            issue(VEC[i].idx, VEC[i].data);
            repeat (PRG + 1) @(negedge clk);
            check($sformatf("R3/R5/R6/R7/R9/R11 vec%0d err", i), {63'd0, prot_err}, {63'd0, VEC[i].err});
            check($sformatf("R3/R5/R6/R9/R11 vec%0d user", i), user_bits, VEC[i].user);
            check($sformatf("R6/R7/R11 vec%0d lock", i), {48'd0, lock_bits}, {48'd0, VEC[i].lock});
            if (VEC[i].err) begin
                // R10 error holds until cleared
                repeat (3) @(negedge clk);
                check("R10 err sticky", {63'd0, prot_err}, 64'd1);
                clear_err();
                check("R10 err cleared", {63'd0, prot_err}, 64'd0);
            end
        end
        check("R8 secure flag after guard only", {63'd0, secure_locked}, 64'd0);

        // R2 R4 busy length and ignored request during busy
        do_reset();
        check("R1 user after reset", user_bits, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        req_valid = 1'b1; req_index = 3'd2; req_data = 16'h00FF;
        @(negedge clk);
        req_index = 3'd2; req_data = 16'h0000;
        bcnt = 0;
        while (busy && bcnt < 50) begin
            bcnt++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        req_valid = 1'b0;
        check("R2 busy length", 64'(bcnt), 64'(PRG));
        check("R2/R4 committed word", user_bits, 64'hFFFF_00FF_FFFF_FFFF);
        repeat (PRG + 2) @(negedge clk);
        check("R4 no late operation", user_bits, 64'hFFFF_00FF_FFFF_FFFF);
        check("R4 no busy afterwards", {63'd0, busy}, 64'd0);

        // R7 R8 clear guard and secure together
        issue(3'd4, 16'h0000);
        repeat (PRG + 1) @(negedge clk);
        check("R7 joint clear no error", {63'd0, prot_err}, 64'd0);
        check("R6/R7 lock bits", {48'd0, lock_bits}, 64'h0000_0000_0000_FFF9);
        check("R8 secure set", {63'd0, secure_locked}, 64'd1);
        issue(3'd4, 16'hFFFF);
        repeat (PRG + 1) @(negedge clk);
        check("R11 lock not restored", {48'd0, lock_bits}, 64'h0000_0000_0000_FFF9);
        check("R8 secure stays", {63'd0, secure_locked}, 64'd1);

        // R10 fault in the same cycle as clear keeps error set
        @(negedge clk);
        req_valid = 1'b1; req_index = 3'd6; req_data = 16'h0000; err_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
        check("R10 fault beats clear", {63'd0, prot_err}, 64'd1);
        check("R9 no change", user_bits, 64'hFFFF_00FF_FFFF_FFFF);
        clear_err();
        check("R10 clear", {63'd0, prot_err}, 64'd0);

        finish_run();
    end
endmodule